// File: doc/BRIEF.md
# SDRAM Column Burst and Read-Latency Sequencer

This block is the column-access engine of a synchronous DRAM, placed behind the command decoder or inside a memory controller's data path. It holds the burst configuration from a mode word and, for each decoded read or write column command, walks through the column addresses of the burst in sequential or interleaved order. For reads it delays a beat strobe by the programmed CAS latency to drive the data-bus output enable. DQM masks read data with a two-clock latency and write data in the same clock.

A column command issued during a burst cuts the running burst short and starts the new one. A burst-stop command ends the burst. A write or a stop also discards read data still in flight in the latency pipe, so the bus is released and never carries read and write data together. A mode bit can limit writes to a single location while reads keep the programmed burst length. Row and bank handling are outside this block.

Top module: `sdram_col_seq`

## Requirements
- R1: `mode_word` is captured on a clock edge with `mode_load` high and governs commands sampled on later edges. Bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8, any other code=1. Bit 3 picks the order (0 sequential, 1 interleaved). Bits [6:4] give the CAS latency: 010 selects 2 and any other value selects 3. Bit 9 set makes writes single-beat. The reset value of the mode is all zeros (length 1, sequential, latency 3, burst writes).
- R2: A read or write command sampled on edge k makes `col_valid` high in the L clock periods that follow edge k, where L is the burst length. `col_addr` equals the start column in the first of these periods and shows beat i in the period after edge k+i.
- R3: In sequential order the address counts up from the start column and wraps inside the L-aligned block that holds the start column.
- R4: In interleaved order the address is the L-aligned block base plus (start offset in the block XOR beat index).
- R5: With the single-write bit set, a write lasts exactly one beat, while reads still last L beats.
- R6: A column command sampled during a burst ends it and starts the new burst on that edge. If both are given at once, write wins over read and either wins over stop. `col_write` is high during write beats.
- R7: A stop sampled on an edge, with no column command on that edge, makes `col_valid` low in the following period.
- R8: A read beat shown after edge k+i drives `dq_oe` high in the period that ends with edge k+i+CL.
- R9: `dqm` sampled high on edge j forces `dq_oe` low in the period that ends with edge j+2.
- R10: A write or an effective stop sampled on an edge clears every read beat in flight, so `dq_oe` stays low until a later read beat comes through. A read interrupting a read keeps the in-flight beats.
- R11: `wdata_en` is high exactly in write-beat periods where `dqm` is low in that same period.
- R12: After reset, `col_valid`, `col_write`, `wdata_en` and `dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` on this edge |
| mode_word | input | 10 | Burst length, order, CAS latency, single-write bit |
| cmd_rd | input | 1 | Decoded read column command |
| cmd_wr | input | 1 | Decoded write column command |
| cmd_stop | input | 1 | Decoded burst-stop command |
| col_in | input | COL_W | Starting column of the command |
| dqm | input | 1 | Data mask |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A burst beat is active |
| col_write | output | 1 | The active beat is a write |
| wdata_en | output | 1 | Write data accepted this period |
| dq_oe | output | 1 | Read data driven on the bus |

## Verification
The hardest case to reach is a latency pipe holding several read beats when a write, a stop or a DQM pulse arrives, and also a mode change while beats are still in flight. Directed sequences place a DQM pulse two edges ahead of a chosen beat and interrupt reads at set points. Long random runs with dense command traffic, frequent interruptions and occasional mode reloads then cover the overlapping combinations.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int MODE_W  = 10;
    localparam int BL_LSB  = 0;
    localparam int ORD_BIT = 3;
    localparam int CL_LSB  = 4;
    localparam int WS_BIT  = 9;
    localparam int BEAT_W  = 3;
    localparam int MAX_CL  = 3;
    localparam int PIPE_D  = MAX_CL - 1;

    typedef struct packed {
        logic [BEAT_W-1:0] len_m1;
        logic              inter;
        logic              cl3;
        logic              wr_single;
    } mode_t;

    function automatic logic [BEAT_W-1:0] len_decode(input logic [2:0] code);
        case (code)
            3'b001:  return 3'd1;
            3'b010:  return 3'd3;
            3'b011:  return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic mode_t mode_decode(input logic [MODE_W-1:0] w);
        mode_t m;
        m.len_m1    = len_decode(w[BL_LSB +: 3]);
        m.inter     = w[ORD_BIT];
        m.cl3       = (w[CL_LSB +: 3] != 3'b010);
        m.wr_single = w[WS_BIT];
        return m;
    endfunction

endpackage

// File: rtl/seq_mode_reg.sv
module seq_mode_reg
    import sdram_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode
);

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d = mode_decode(word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= mode_decode('0);
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    assert_latency_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mode_q.cl3 == ($past(word[CL_LSB +: 3]) != 3'b010)));

endmodule

// File: rtl/seq_burst_ctr.sv
module seq_burst_ctr
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] col_in,
    input  mode_t            mode,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write,
    output logic             rd_beat,
    output logic             flush
);

    localparam int HI_W = COL_W - BEAT_W;

    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic              inter;
        logic [BEAT_W-1:0] len_m1;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  start;
    } burst_t;

    burst_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        flush = 1'b0;
        if (cmd_wr || cmd_rd) begin
            s_d.active = 1'b1;
            s_d.is_wr  = cmd_wr;
            s_d.inter  = mode.inter;
            s_d.len_m1 = (cmd_wr && mode.wr_single) ? '0 : mode.len_m1;
            s_d.beat   = '0;
            s_d.start  = col_in;
            flush      = cmd_wr;
        end else if (cmd_stop) begin
            s_d.active = 1'b0;
            flush      = 1'b1;
        end else if (s_q.active) begin
            if (s_q.beat == s_q.len_m1) begin
                s_d.active = 1'b0;
            end else begin
                s_d.beat = s_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic [BEAT_W-1:0] low_start, low_seq, low_int, low_sel;

    always_comb begin
        low_start = s_q.start[BEAT_W-1:0];
        low_seq   = ((low_start + s_q.beat) & s_q.len_m1) | (low_start & ~s_q.len_m1);
        low_int   = low_start ^ s_q.beat;
        low_sel   = s_q.inter ? low_int : low_seq;
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign col_addr = {s_q.start[COL_W-1:BEAT_W], low_sel};
        end else begin : g_lo
            assign col_addr = low_sel[COL_W-1:0];
        end
    endgenerate

    assign col_valid = s_q.active;
    assign col_write = s_q.active & s_q.is_wr;
    assign rd_beat   = s_q.active & ~s_q.is_wr;

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |=> (col_valid && col_addr == $past(col_in)));

    assert_wr_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> col_write);

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_rd && !cmd_wr) |=> !col_valid);

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && mode.wr_single) |=> ##1 (!col_valid || $past(cmd_rd || cmd_wr)));

endmodule

// File: rtl/seq_read_pipe.sv
module seq_read_pipe
    import sdram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_beat,
    input  logic flush,
    input  logic dqm,
    input  logic cl3,
    output logic dq_oe
);

    typedef struct packed {
        logic [PIPE_D-1:0] sh;
        logic [1:0]        mask;
    } pipe_t;

    pipe_t p_d, p_q;
    logic  tap;

    always_comb begin
        p_d      = p_q;
        p_d.mask = {p_q.mask[0], dqm};
        if (flush) begin
            p_d.sh = '0;
        end else if (PIPE_D > 1) begin
            p_d.sh = {p_q.sh[PIPE_D-2:0], rd_beat};
        end else begin
            p_d.sh = rd_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        tap   = cl3 ? p_q.sh[PIPE_D-1] : p_q.sh[0];
        dq_oe = tap & ~p_q.mask[1];
    end

    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dq_oe);

    assert_dqm_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dqm |-> ##2 !dq_oe);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [9:0]       mode_word,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] col_in,
    input  logic             dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write,
    output logic             wdata_en,
    output logic             dq_oe
);

    mode_t mode;
    logic  rd_beat;
    logic  flush;

    seq_mode_reg u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mode_load),
        .word (mode_word),
        .mode (mode)
    );

    seq_burst_ctr #(.COL_W(COL_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_rd   (cmd_rd),
        .cmd_wr   (cmd_wr),
        .cmd_stop (cmd_stop),
        .col_in   (col_in),
        .mode     (mode),
        .col_addr (col_addr),
        .col_valid(col_valid),
        .col_write(col_write),
        .rd_beat  (rd_beat),
        .flush    (flush)
    );

    seq_read_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_beat(rd_beat),
        .flush  (flush),
        .dqm    (dqm),
        .cl3    (mode.cl3),
        .dq_oe  (dq_oe)
    );

    assign wdata_en = col_write & ~dqm;

    assert_oe_not_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        col_write |-> !dq_oe);

endmodule

// File: tb/sim_sdram_col_seq.sv
`timescale 1ns/1ps
module sim_sdram_col_seq;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [9:0]       mode_word = '0;
    logic             cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0;
    logic [COL_W-1:0] col_in = '0;
    logic             dqm = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid, col_write, wdata_en, dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sdram_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .col_in(col_in),
        .dqm(dqm), .col_addr(col_addr), .col_valid(col_valid),
        .col_write(col_write), .wdata_en(wdata_en), .dq_oe(dq_oe)
    );

    // reference model state (post-edge)
    int m_act, m_wr, m_inter, m_len, m_beat, m_start;
    int md_len, md_inter, md_cl, md_ws;
    int sh0, sh1, dq1, dq2;

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int addr_of(input int start, input int len, input int inter, input int beat);
        int off  = start % len;
        int base = start - off;
        if (inter != 0) return base + (off ^ beat);
        return base + ((off + beat) % len);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_wr = 0; m_inter = 0; m_len = 1; m_beat = 0; m_start = 0;
        md_len = 1; md_inter = 0; md_cl = 3; md_ws = 0;
        sh0 = 0; sh1 = 0; dq1 = 0; dq2 = 0;
    endtask

    task automatic model_edge(input bit rd, input bit wr, input bit stop,
                              input int col, input bit m, input bit ld, input int mw);
        int cur_rd = (m_act != 0 && m_wr == 0) ? 1 : 0;
        int fl     = (wr || (stop && !rd)) ? 1 : 0;
        sh1 = fl ? 0 : sh0;
        sh0 = fl ? 0 : cur_rd;
        dq2 = dq1;
        dq1 = m;
        if (wr || rd) begin
            m_act = 1; m_wr = wr; m_inter = md_inter;
            m_len = (wr && md_ws != 0) ? 1 : md_len;
            m_beat = 0; m_start = col;
        end else if (stop) begin
            m_act = 0;
        end else if (m_act != 0) begin
            if (m_beat == m_len - 1) m_act = 0;
            else m_beat++;
        end
        if (ld) begin
            md_len   = len_of(mw & 7);
            md_inter = (mw >> 3) & 1;
            md_cl    = (((mw >> 4) & 7) == 2) ? 2 : 3;
            md_ws    = (mw >> 9) & 1;
        end
    endtask

    task automatic compare_model();
        int exp_oe = (md_cl == 3 ? sh1 : sh0) != 0 && dq2 == 0;
        int exp_we = (m_act != 0 && m_wr != 0 && !dqm) ? 1 : 0;
        chk(col_valid == (m_act != 0), "R2", "col_valid", col_valid, m_act);
        chk(col_write == (m_act != 0 && m_wr != 0), "R6", "col_write", col_write,
            (m_act != 0 && m_wr != 0));
        if (m_act != 0) begin
            int ea = addr_of(m_start, m_len, m_inter, m_beat);
            chk(col_addr == ea[COL_W-1:0], m_inter != 0 ? "R4" : "R3", "col_addr",
                col_addr, ea);
        end
        chk(wdata_en == exp_we, "R11", "wdata_en", wdata_en, exp_we);
        chk(dq_oe == exp_oe, "R8", "dq_oe", dq_oe, exp_oe);
    endtask

    task automatic step(input bit rd, input bit wr, input bit stop, input int col,
                        input bit m, input bit ld, input int mw);
        @(negedge clk);
        cmd_rd = rd; cmd_wr = wr; cmd_stop = stop; col_in = col[COL_W-1:0];
        dqm = m; mode_load = ld; mode_word = mw[9:0];
        #1;
        compare_model();
        @(posedge clk);
        #1;
        model_edge(rd, wr, stop, col, m, ld, mw);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(!col_valid && !col_write && !wdata_en && !dq_oe, "R12", "reset outputs",
            {col_valid, col_write, wdata_en, dq_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R8: BL4 sequential, CL2, start 5 -> 5,6,7,4
        step(0, 0, 0, 0, 0, 1, 'h022);
        step(1, 0, 0, 5, 0, 0, 0);
        chk(col_addr == 5, "R2", "beat0 addr", col_addr, 5);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_addr == 6, "R3", "beat1 addr", col_addr, 6);
        chk(dq_oe == 1, "R8", "CL2 first data", dq_oe, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_addr == 7, "R3", "beat2 addr", col_addr, 7);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_addr == 4, "R3", "wrap addr", col_addr, 4);
        idle(4);

        // R4: BL4 interleaved start 6 -> 6,7,4,5
        step(0, 0, 0, 0, 0, 1, 'h02A);
        step(1, 0, 0, 6, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_addr == 7, "R4", "ilv beat1", col_addr, 7);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_addr == 4, "R4", "ilv beat2", col_addr, 4);
        idle(4);

        // R5: single-location writes, reads still burst
        step(0, 0, 0, 0, 0, 1, 'h22A);
        step(0, 1, 0, 6, 0, 0, 0);
        chk(col_write == 1, "R5", "write beat", col_write, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_valid == 0, "R5", "single write ends", col_valid, 0);
        step(1, 0, 0, 6, 0, 0, 0);
        idle(3);
        chk(col_valid == 1 && col_addr == 5, "R5", "read still bursts", col_addr, 5);
        idle(4);

        // R6: interrupt and priority
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 8, 0, 0, 0);
        chk(col_addr == 8, "R6", "interrupt restarts", col_addr, 8);
        step(1, 1, 1, 16, 0, 0, 0);
        chk(col_write == 1, "R6", "write wins", col_write, 1);
        idle(4);

        // R7 R10: stop ends read, in-flight data dropped
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        chk(col_valid == 0, "R7", "stop ends burst", col_valid, 1'b0);
        chk(dq_oe == 0, "R10", "flush after stop", dq_oe, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(dq_oe == 0, "R10", "flush holds", dq_oe, 0);
        idle(3);

        // R1 R9: CL field 000 -> latency 3; DQM two-clock mask
        step(0, 0, 0, 0, 0, 1, 'h002);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(dq_oe == 0, "R1", "no data before CL3", dq_oe, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk(dq_oe == 1, "R1", "CL3 first data", dq_oe, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(dq_oe == 0, "R9", "dqm masked beat", dq_oe, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(dq_oe == 1, "R9", "next beat unmasked", dq_oe, 1);
        idle(4);

        // R1: reserved length code -> 1 beat
        step(0, 0, 0, 0, 0, 1, 'h025);
        step(1, 0, 0, 3, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(col_valid == 0, "R1", "reserved length is 1", col_valid, 0);
        idle(3);

        // random traffic
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            int r   = $urandom % 100;
            bit rd  = (r < 18) || (r >= 30 && r < 33);
            bit wr  = (r >= 18 && r < 26) || (r >= 30 && r < 33);
            bit sp  = (r >= 26 && r < 30);
            bit m   = ($urandom % 5) == 0;
            bit ld  = ($urandom % 40) == 0;
            int mw  = $urandom % 1024;
            step(rd, wr, sp, $urandom % 512, m, ld, mw);
        end
        idle(6);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule